// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog built from an 8-bit prescaler and a 16-bit down counter. Both count on a tick that the block derives from its own clock, one tick every fourth cycle. Once software has switched the block into watchdog mode, it must restart the block regularly. A restart is one write of AAh followed by one write of 55h to the counter-low register. If the count runs out first, the block drives a fixed-length reset-request pulse and then starts a new period by itself.

Four byte registers are reached through a single-cycle write port. The prescaler and the two counter bytes are reload values, and they are copied into the running counters only at a reload event. There are three reload events: entry into watchdog mode, a completed key, and the end of a reset pulse. The control register holds an active-low enable bit. Writing that bit to zero enters watchdog mode, and only the block reset leaves it.

The control state machine has three states. In CS_TIMER the block is idle and the counters are stopped. In CS_RUN the counters run. In CS_FIRE the reset pulse is driven. Its transitions are:
- TIMER→RUN on mode entry, with a load.
- RUN→RUN on a key restart, with a load.
- RUN→FIRE at terminal count.
- FIRE→RUN at the end of the pulse, with a load.

The key state machine has two states, KS_IDLE and KS_HALF. KS_IDLE moves to KS_HALF when AAh is written to the low register. Any write to the low register moves KS_HALF back to KS_IDLE. When that write is 55h, it also issues the restart.

Top module: `kwdt_top`

## Requirements
- R1: After reset, rst_req is low and the block is in timer mode, where nothing counts and no reset request is ever raised.
- R2: A write takes effect at the clock edge on which wr_en is high. Address 0 holds the prescaler reload, address 1 holds counter bits 7:0, address 2 holds counter bits 15:8, and address 3 holds the control byte, whose bit 0 is the active-low enable (reset value 1).
- R3: Writing address 3 with bit 0 clear enters watchdog mode. The counters load one cycle after that write edge, and the first reset request rises 1+4(P+1)(C+1) cycles after the write edge.
- R4: Ticks come every 4 cycles. On each tick the prescaler steps down, and it wraps from 0 to the active prescaler value while the counter steps down. The terminal count is a tick that finds both at zero, so a period is 4(P+1)(C+1) cycles.
- R5: The reset request stays high for PULSE_LEN (4) cycles. At its end the counters reload, so consecutive rises are 4(P+1)(C+1)+PULSE_LEN cycles apart.
- R6: In watchdog mode, writing AAh and then 55h to address 1 reloads the counters on the 55h write edge. The next rise then comes 4(P+1)(C+1) cycles after that edge.
- R7: If the write to address 1 after AAh is any other byte, including AAh, the sequence is dropped. A 55h that does not follow an accepted AAh has no effect.
- R8: Writes to addresses 0, 2 and 3 between AAh and 55h leave the key sequence in progress.
- R9: In watchdog mode, writes to address 1 are key bytes only and leave the counter-low reload value unchanged.
- R10: A prescaler write in mid-period does not change the current period. The new value takes effect from the next reload.
- R11: Once watchdog mode is entered, setting the enable bit back to 1 has no effect.
- R12: A key completed on the same edge as the terminal tick wins: no pulse is issued, and the counters reload.
- R13: A key completed while the pulse is high is ignored, and the pulse runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write byte |
| rst_req | output | 1 | Reset request pulse |

## Verification
Two events can fall on the same edge: completion of the restart key and the terminal tick. The bench counts cycles from the mode-entry write to find the terminal edge of a short period. It places the AAh write a little earlier and lands the 55h write exactly on that edge. The design is judged correct only if no pulse appears and the next rise arrives a full period after that edge. A second race puts the 55h write inside the pulse, and the pulse must keep its full length.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [1:0] {
        CS_TIMER = 2'd0,
        CS_RUN   = 2'd1,
        CS_FIRE  = 2'd2
    } ctl_state_t;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_HALF = 1'b1
    } key_state_t;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_PRE = 2'd0;
    localparam logic [ADDR_W-1:0] A_LO  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd3;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pre_rld,
    output logic [CNT_W-1:0]  cnt_rld,
    output logic              wd_on
);

    logic [DATA_W-1:0] pre_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic              on_q;

    // Decoded write strobes, one per register.
    logic hit_pre;
    logic hit_lo;
    logic hit_hi;
    logic hit_ctl;

    always_comb begin
        hit_pre = wr_en && (wr_addr == A_PRE);
        hit_lo  = wr_en && (wr_addr == A_LO);
        hit_hi  = wr_en && (wr_addr == A_HI);
        hit_ctl = wr_en && (wr_addr == A_CTL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            lo_q  <= '1;
            hi_q  <= '1;
        end else begin
            if (hit_pre) begin
                pre_q <= wr_data;
            end
            // Once armed, the low address carries key bytes only.
            if (hit_lo && !on_q) begin
                lo_q <= wr_data;
            end
            if (hit_hi) begin
                hi_q <= wr_data;
            end
        end
    end

    // Sticky mode flag: the active-low enable bit can only arm the block.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q <= 1'b0;
        end else if (hit_ctl && !wr_data[0]) begin
            on_q <= 1'b1;
        end
    end

    assign pre_rld = pre_q;
    assign cnt_rld = {hi_q, lo_q};
    assign wd_on   = on_q;

endmodule

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_A  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              restart
);

    key_state_t ks_q;
    key_state_t ks_d;
    logic       key_hit;

    assign key_hit = armed && wr_en && (wr_addr == A_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= KS_IDLE;
        end else begin
            ks_q <= ks_d;
        end
    end

    always_comb begin
        ks_d = ks_q;
        unique case (ks_q)
            KS_IDLE: begin
                if (key_hit && (wr_data == KEY_A)) begin
                    ks_d = KS_HALF;
                end
            end
            KS_HALF: begin
                // Any byte to the low register ends this attempt.
                if (key_hit) begin
                    ks_d = KS_IDLE;
                end
            end
            default: ks_d = KS_IDLE;
        endcase
        if (!armed) begin
            ks_d = KS_IDLE;
        end
    end

    always_comb begin
        restart = 1'b0;
        unique case (ks_q)
            KS_IDLE: restart = 1'b0;
            KS_HALF: restart = key_hit && (wr_data == KEY_B);
            default: restart = 1'b0;
        endcase
    end

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    parameter int DIV   = 4,
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_rld,
    input  logic [CNT_W-1:0] cnt_rld,
    output logic             term
);

    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] act_pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = run && (div_q == DIV_W'(DIV - 1));
    assign term = tick && (pre_q == '0) && (cnt_q == '0);

    // Clock-enable divider, realigned on every load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (load) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
        end
    end

    // The prescaler wraps to a copy taken at load time, so a later
    // register write waits for the next load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q     <= '0;
            act_pre_q <= '0;
            cnt_q     <= '0;
        end else if (load) begin
            pre_q     <= pre_rld;
            act_pre_q <= pre_rld;
            cnt_q     <= cnt_rld;
        end else if (tick) begin
            if (pre_q == '0) begin
                pre_q <= act_pre_q;
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    localparam int PL_W = $clog2(PULSE_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_on,
    input  logic       restart,
    input  logic       term,
    output logic       load,
    output logic       run,
    output logic       rst_req,
    output ctl_state_t state
);

    ctl_state_t st_q;
    ctl_state_t st_d;
    logic [PL_W-1:0] pl_q;
    logic            pulse_done;
    logic            rq_q;

    assign pulse_done = (st_q == CS_FIRE) && (pl_q == PL_W'(PULSE_LEN - 1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CS_TIMER;
        end else begin
            st_q <= st_d;
        end
    end

    // Pulse length counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q <= '0;
        end else if (st_q == CS_FIRE) begin
            pl_q <= pl_q + 1'b1;
        end else begin
            pl_q <= '0;
        end
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            CS_TIMER: begin
                if (wd_on) begin
                    st_d = CS_RUN;
                    load = 1'b1;
                end
            end
            CS_RUN: begin
                // A key on the terminal edge takes priority.
                if (restart) begin
                    load = 1'b1;
                end else if (term) begin
                    st_d = CS_FIRE;
                end
            end
            CS_FIRE: begin
                if (pulse_done) begin
                    st_d = CS_RUN;
                    load = 1'b1;
                end
            end
            default: st_d = CS_TIMER;
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= 1'b0;
        end else begin
            rq_q <= (st_d == CS_FIRE);
        end
    end

    assign run     = (st_q == CS_RUN);
    assign rst_req = rq_q;
    assign state   = st_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                DIV       = 4,
    parameter int                PULSE_LEN = 4,
    parameter logic [DATA_W-1:0] KEY_A     = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B     = 8'h55,
    localparam int               CNT_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_req
);

    logic [DATA_W-1:0] pre_rld;
    logic [CNT_W-1:0]  cnt_rld;
    logic              wd_on;
    logic              restart;
    logic              term;
    logic              load;
    logic              run;
    ctl_state_t        state;

    kwdt_regs #(.DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pre_rld (pre_rld),
        .cnt_rld (cnt_rld),
        .wd_on   (wd_on)
    );

    kwdt_keyseq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) key_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (wd_on),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .restart (restart)
    );

    kwdt_count #(.PRE_W(DATA_W), .CNT_W(CNT_W), .DIV(DIV)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .run     (run),
        .pre_rld (pre_rld),
        .cnt_rld (cnt_rld),
        .term    (term)
    );

    kwdt_ctrl #(.PULSE_LEN(PULSE_LEN)) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_on   (wd_on),
        .restart (restart),
        .term    (term),
        .load    (load),
        .run     (run),
        .rst_req (rst_req),
        .state   (state)
    );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    localparam int HC_W = $clog2(PULSE_LEN + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req,
    input logic       wd_on,
    input logic       restart,
    input logic       term,
    input ctl_state_t state
);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (rst_req) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    p_quiet_timer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_on |-> !rst_req);

    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |=> wd_on);

    p_term_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_RUN && term && !restart) |=> rst_req);

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (hi_cnt == HC_W'(PULSE_LEN)));

    p_key_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_RUN && term && restart) |=> !rst_req);

    p_key_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_on |-> !restart);

endmodule

bind kwdt_top kwdt_chk #(.PULSE_LEN(PULSE_LEN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_req (rst_req),
    .wd_on   (wd_on),
    .restart (restart),
    .term    (term),
    .state   (state)
);

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/100ps
module kwdt_top_tb_top;

    localparam int L = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rst_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = -1;
    int last_len = 0;
    int hi_run = 0;
    int wr_edge = 0;
    logic prev_rq = 1'b0;

    kwdt_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rst_req (rst_req)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_req && !prev_rq) begin
            rises = rises + 1;
            last_rise = cyc;
        end
        if (rst_req) begin
            hi_run = hi_run + 1;
        end else if (prev_rq) begin
            last_len = hi_run;
            hi_run = 0;
        end
        prev_rq = rst_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        wr_edge = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic wait_rise(output int e, input int limit);
        int r0 = rises;
        e = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            #1;
            if (rises != r0) begin
                e = last_rise;
                break;
            end
        end
    endtask

    task automatic arm(input int p, input int c, output int e0);
        do_reset();
        wr(2'd0, 8'(p));
        wr(2'd1, 8'(c & 255));
        wr(2'd2, 8'(c >> 8));
        wr(2'd3, 8'h00);
        e0 = wr_edge;
    endtask

    initial begin
        #(200000 * 5);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0, r1, r2, n, eb, t;
        do_reset();
        // R1: quiet after reset and in timer mode
        chk(rst_req == 1'b0, "R1 reset value", int'(rst_req), 0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        r1 = rises;
        repeat (200) @(negedge clk);
        chk(rises == r1, "R1 timer mode silent", rises - r1, 0);

        // R2 R3 R4 R5: sweep of small prescaler and counter values
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                n = 4 * (p + 1) * (c + 1);
                arm(p, c, e0);
                wait_rise(r1, 2000);
                chk(r1 == e0 + 1 + n, "R3 R4 first rise", r1 - e0, 1 + n);
                wait_rise(r2, 2000);
                chk(r2 == r1 + n + L, "R5 rise spacing", r2 - r1, n + L);
                chk(last_len == L, "R5 pulse length", last_len, L);
            end
        end

        // R2: counter high byte
        arm(0, 256, e0);
        wait_rise(r1, 3000);
        chk(r1 == e0 + 1 + 4 * 257, "R2 high byte", r1 - e0, 1 + 4 * 257);

        // R6 R9: key restart; period must keep reload low = 2
        arm(1, 2, e0);
        wait_cyc(e0 + 8);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'h55);
        eb = wr_edge;
        wait_rise(r1, 2000);
        chk(r1 == eb + 24, "R6 R9 restart", r1 - eb, 24);

        // R7: wrong byte after AA
        arm(1, 2, e0);
        wait_cyc(e0 + 6);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'h55);
        wait_rise(r1, 2000);
        chk(r1 == e0 + 25, "R7 bad second byte", r1 - e0, 25);

        // R7: AA AA 55
        arm(1, 2, e0);
        wait_cyc(e0 + 6);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'h55);
        wait_rise(r1, 2000);
        chk(r1 == e0 + 25, "R7 repeated AA", r1 - e0, 25);

        // R7: lone 55
        arm(1, 2, e0);
        wait_cyc(e0 + 8);
        wr(2'd1, 8'h55);
        wait_rise(r1, 2000);
        chk(r1 == e0 + 25, "R7 lone 55", r1 - e0, 25);

        // R8: other address between the key bytes
        arm(1, 2, e0);
        wait_cyc(e0 + 6);
        wr(2'd1, 8'hAA);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h55);
        eb = wr_edge;
        wait_rise(r1, 2000);
        chk(r1 == eb + 24, "R8 interleaved write", r1 - eb, 24);

        // R10: prescaler change mid-period
        arm(1, 3, e0);
        wait_cyc(e0 + 5);
        wr(2'd0, 8'h03);
        wait_rise(r1, 2000);
        chk(r1 == e0 + 33, "R10 current period kept", r1 - e0, 33);
        wait_rise(r2, 2000);
        chk(r2 == r1 + 64 + L, "R10 new period", r2 - r1, 64 + L);

        // R11: setting the enable bit again
        arm(1, 2, e0);
        wr(2'd3, 8'h01);
        wait_rise(r1, 2000);
        chk(r1 == e0 + 25, "R11 still armed", r1 - e0, 25);
        wait_rise(r2, 2000);
        chk(r2 == r1 + 24 + L, "R11 keeps cycling", r2 - r1, 24 + L);

        // R12: key completes on the terminal edge
        arm(0, 3, e0);
        t = e0 + 17;
        wait_cyc(t - 6);
        wr(2'd1, 8'hAA);
        wait_cyc(t - 2);
        wr(2'd1, 8'h55);
        chk(wr_edge == t, "R12 alignment", wr_edge, t);
        wait_rise(r1, 2000);
        chk(r1 == t + 16, "R12 key wins", r1 - t, 16);

        // R13: key completes inside the pulse
        arm(0, 3, e0);
        t = e0 + 17;
        wait_cyc(t - 4);
        wr(2'd1, 8'hAA);
        wait_rise(r1, 2000);
        wr(2'd1, 8'h55);
        wait_rise(r2, 2000);
        chk(last_len == L, "R13 pulse length", last_len, L);
        chk(r2 == r1 + 16 + L, "R13 spacing", r2 - r1, 16 + L);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule